// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt line to a processor. Each line is edge-latched into a request register. A per-line mask and a priority order select one winner. The interrupt output stays high while that winner outranks every source already in service. The processor answers with a single-cycle acknowledge pulse. One cycle later the block presents an 8-bit vector that names the winner, and it moves the winner from the request register into the in-service register.

Software uses a small write port to set three things: the mask, the priority mode and the upper bits of the vector. A write to a fourth address is an end-of-interrupt command. That command retires the highest-priority in-service source. When rotation is enabled, the retired source also becomes the lowest-priority position.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low, no line is masked, the fixed (non-rotating) order is active and the vector base is 0x00.
- R2: A request is latched on a low-to-high transition of `irq_in[i]`. A line held high after its request was acknowledged does not request again. It must go low and then rise again.
- R3: In fixed order, line 0 has the highest priority and line 7 the lowest. The lowest-numbered pending line is the winner.
- R4: Writing address 0 sets the mask, where bit i = 1 disables line i. A masked line that has a latched request cannot raise `int_req`. The request stays latched and is served once the line is unmasked.
- R5: If `ack` is high in a cycle where `int_req` is high, then in the next cycle `vec_valid` is high for exactly one cycle. In that cycle `vec_out` = {base[7:3], winner number[2:0]}. The winner's request is cleared and its in-service bit is set.
- R6: An `ack` pulse while `int_req` is low has no effect: `vec_valid` stays low.
- R7: While any in-service bit is set, `int_req` is high only if a pending unmasked request has strictly higher priority than every in-service source. Otherwise `int_req` is low.
- R8: A write to address 3 (any data) is an end-of-interrupt command. It clears the highest-priority in-service bit, which lets waiting lower-priority requests raise `int_req`.
- R9: Writing address 1 with bit 0 = 1 selects rotating order. In this mode an end-of-interrupt makes the retired source the lowest priority. The source numbered one above it (modulo 8) becomes the highest priority.
- R10: Writing address 2 sets the vector base. Only bits 7:3 of the base appear in `vec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, edge-detected |
| ack | input | 1 | Single-cycle acknowledge from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 mode, 2 vector base, 3 end-of-interrupt |
| wr_data | input | 8 | Register write data |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the acknowledged source |
| vec_valid | output | 1 | `vec_out` is valid this cycle |

## Verification
The bench first holds lines high after they have been serviced. A level-sensitive design would fire again there and produce vectors the scoreboard does not expect. Simultaneous requests with a line already in service probe nesting. A design that compares with "higher or equal" instead of "strictly higher", or that ignores the in-service register, would raise the interrupt too early. After each end-of-interrupt in rotating mode, the bench checks the winner among requests that arrive together. A design that forgets to move the pointer, or moves it to the wrong source, returns the wrong vector. The bench also issues stray acknowledges and masks a line to confirm that neither produces a vector.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             ack,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             int_req,
  output logic [7:0]       vec_out,
  output logic             vec_valid
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] irq_q, req, isr, mask;
  logic            rotate;
  logic [7:0]      base;
  logic [IW-1:0]   lo_ptr;

  function automatic logic [IW-1:0] rank(input logic [IW-1:0] id, input logic [IW-1:0] lo);
    rank = id - lo - IW'(1);
  endfunction

  function automatic logic [IW-1:0] pick(input logic [NSRC-1:0] v, input logic [IW-1:0] lo);
    logic [IW-1:0] id;
    pick = lo;
    for (int r = NSRC - 1; r >= 0; r--) begin
      id = lo + IW'(1) + IW'(r);
      if (v[id]) pick = id;
    end
  endfunction

  wire [IW-1:0]   eff_lo = rotate ? lo_ptr : IW'(NSRC - 1);
  wire [NSRC-1:0] pend   = req & ~mask;
  wire [IW-1:0]   win    = pick(pend, eff_lo);
  wire [IW-1:0]   itop   = pick(isr, eff_lo);
  wire            eoi    = wr_en && wr_addr == 2'd3;
  wire            take   = ack && int_req;

  assign int_req = (|pend) && (isr == '0 || rank(win, eff_lo) < rank(itop, eff_lo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      req       <= '0;
      isr       <= '0;
      mask      <= '0;
      rotate    <= 1'b0;
      base      <= '0;
      lo_ptr    <= IW'(NSRC - 1);
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      vec_valid <= take;
      begin
        logic [NSRC-1:0] r_n, i_n;
        r_n = req;
        i_n = isr;
        if (take) begin
          r_n[win] = 1'b0;
          i_n[win] = 1'b1;
          vec_out  <= {base[7:IW], win};
        end
        if (eoi && isr != '0) begin
          i_n[itop] = 1'b0;
          if (rotate) lo_ptr <= itop;
        end
        req <= r_n | (irq_in & ~irq_q);
        isr <= i_n;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: mask   <= wr_data[NSRC-1:0];
          2'd1: rotate <= wr_data[0];
          2'd2: base   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assert_vec_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vec_valid && vec_out[7:IW] == $past(base[7:IW]));
  assert_vec_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack) && $past(int_req));
  assert_isr_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !eoi |=> $countones(isr) == $past($countones(isr)) + 1);
  assert_stray_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !int_req |=> !vec_valid);
  assert_all_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '1 |-> !int_req);
  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !take && isr != '0 |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       ack = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       int_req;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  logic       done = 1'b0;

  always #10 clk = ~clk;

  prio_intc dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .wr_en(wr_en),
                 .wr_addr(wr_addr), .wr_data(wr_data), .int_req(int_req),
                 .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] expv);
    @(negedge clk);
    exp_q.push_back(expv);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5/R6: unexpected vector actual %h expected none", vec_out);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check("R5 vector", vec_out, e);
      end
    end
  end

  initial begin
    #4ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rst_n = 1'b1;
    // R1: default base 0, no mask, fixed order
    set_irq(8'h08);
    check("R1 int after reset", {7'd0, int_req}, 8'h01);
    do_ack(8'h03);
    wr(2'd3, 8'h00);
    set_irq(8'h00);
    // R10 base
    wr(2'd2, 8'h47);
    // R3 simultaneous 5 and 2 -> 2 wins
    set_irq(8'h24);
    check("R2 edge latched", {7'd0, int_req}, 8'h01);
    do_ack(8'h42);
    check("R7 lower waits", {7'd0, int_req}, 8'h00);
    set_irq(8'h26);
    check("R7 higher preempts", {7'd0, int_req}, 8'h01);
    do_ack(8'h41);
    wr(2'd3, 8'h00);
    check("R8 eoi clears 1 only", {7'd0, int_req}, 8'h00);
    wr(2'd3, 8'h00);
    check("R8 eoi releases 5", {7'd0, int_req}, 8'h01);
    do_ack(8'h45);
    wr(2'd3, 8'h00);
    repeat (3) @(negedge clk);
    check("R2 held level no rerequest", {7'd0, int_req}, 8'h00);
    // R6 stray ack
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R6 stray ack", {7'd0, vec_valid}, 8'h00);
    set_irq(8'h00);
    set_irq(8'h04);
    do_ack(8'h42);
    wr(2'd3, 8'h00);
    set_irq(8'h00);
    // R4 mask
    wr(2'd0, 8'h10);
    set_irq(8'h10);
    check("R4 masked", {7'd0, int_req}, 8'h00);
    wr(2'd0, 8'h00);
    check("R4 unmask serves", {7'd0, int_req}, 8'h01);
    do_ack(8'h44);
    wr(2'd3, 8'h00);
    set_irq(8'h00);
    // R9 rotating
    wr(2'd1, 8'h01);
    set_irq(8'h41);
    do_ack(8'h40);
    wr(2'd3, 8'h00);
    do_ack(8'h46);
    wr(2'd3, 8'h00);
    set_irq(8'h00);
    set_irq(8'h81);
    do_ack(8'h47);
    check("R9 rotated 0 below 7", {7'd0, int_req}, 8'h00);
    wr(2'd3, 8'h00);
    do_ack(8'h40);
    wr(2'd3, 8'h00);
    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule